// File: doc/BRIEF.md
# Triggered DAC Holding Controller

This block is the digital front end for a pair of DAC channels. Each channel has a holding register that software or a DMA engine loads with a 12-bit sample, right aligned in the channel's lane of the write bus, and an output register that drives the converter. Loading the holding register leaves the converter value unchanged. Only a trigger moves the held sample into the output register. The trigger is either a self-clearing software trigger bit or a rising edge on one of several hardware trigger inputs; a per-channel select field picks which input counts.

Hardware trigger inputs may come from other clock domains, such as a timer's trigger output. They pass through a two-flop synchronizer and are then edge detected. When DMA is enabled on a channel, every hardware trigger also raises that channel's DMA request, so the next sample is fetched. The request stays up until the DMA engine writes the holding register with an acknowledge. Software triggers never raise a request. If both channels are preloaded and select the same trigger, they update on the same clock edge. When triggering is disabled on a channel, its output simply follows the holding register one clock behind.

Top module: `dac_hold_ctrl`

## Requirements
- R1: After reset, every lane of `dac_out`, every bit of `dma_req` and every bit of `sw_trig_q` is 0.
- R2: With `trig_en[c]`=1, a write to channel c's holding register does not change `dac_out` lane c unless a trigger acts on that channel.
- R3: The holding register keeps only the most recent write. When several writes come before a trigger, the trigger outputs the last one. Lane c is `wr_data[12c+11:12c]`.
- R4: A 1 on `sw_trig_set[c]` at clock edge E sets `sw_trig_q[c]` at E. At E+1, with `trig_en[c]`=1, lane c of `dac_out` takes the holding value and `sw_trig_q[c]` clears (provided `sw_trig_set[c]` is 0 then).
- R5: `trig_sel[2c+1:2c]` selects `hw_trig[k]` for channel c. The edge at which `hw_trig[k]` is first seen high is E0. A low-to-high change on the selected input updates lane c at edge E0+2. Unselected inputs have no effect, and an input held high does not trigger again.
- R6: A hardware trigger on channel c with `dma_en[c]`=1 sets `dma_req[c]` on the same edge that updates the output. The request stays set until an edge at which `dma_ack[c]`=1 and no new hardware trigger occurs.
- R7: A software trigger never sets `dma_req`, even with `dma_en` set.
- R8: With `trig_en[c]`=0, lane c follows the holding register one edge after the write. Hardware and software triggers then neither alter it nor raise `dma_req[c]`.
- R9: Two channels preloaded and selecting the same hardware input update their outputs, and raise their requests, on the same edge.
- R10: A trigger that coincides with a holding write outputs the value held before that write. The new value waits for a later trigger.
- R11: With `dma_en[c]`=0, a hardware trigger updates lane c but leaves `dma_req[c]` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NCH | Per-channel holding register write strobe |
| wr_data | input | NCH*DW | Per-channel right-aligned sample lanes |
| trig_en | input | NCH | Per-channel trigger enable (0 = output follows holding) |
| trig_sel | input | NCH*SELW | Per-channel hardware trigger input select |
| hw_trig | input | NHW | Asynchronous hardware trigger inputs |
| sw_trig_set | input | NCH | Sets the per-channel software trigger bit |
| dma_en | input | NCH | Per-channel DMA request enable |
| dma_ack | input | NCH | DMA acknowledge, given with the DMA's holding write |
| dac_out | output | NCH*DW | Output registers driving the converters |
| sw_trig_q | output | NCH | Software trigger bits (self-clearing) |
| dma_req | output | NCH | Per-channel DMA request |

## Verification
A wrong holding value stays hidden until the next trigger moves it into `dac_out`, which is two edges after a hardware input rises or one edge after a software trigger bit is set. The bench therefore triggers after every write it checks. A broken synchronizer or edge detector shows up as an update one edge too early or too late, or as a second request while an input stays high. A mis-decoded select field shows up as an output change on an unselected input, and the bench finds it by sweeping every pairing of select value and input on both channels. A stray DMA set path shows up as a request after a software trigger or with DMA disabled, and the bench checks for it on the edge after each trigger.

// File: rtl/dac_hold_pkg.sv
// Package: shared types for the triggered DAC holding controller.
// Assumes nothing beyond standard SystemVerilog enums.
package dac_hold_pkg;

    // Reason the output register reloads on the current edge
    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_SW     = 2'd1,
        XFER_HW     = 2'd2,
        XFER_FOLLOW = 2'd3
    } xfer_src_e;

    // Width of a select field able to address n inputs (at least 1)
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dac_trig_sync.sv
// Module: dac_trig_sync
// Synchronizes asynchronous hardware trigger inputs through STAGES flops
// and emits a one-cycle pulse on each rising edge.
// Assumes each input stays high or low for at least one clock period.
module dac_trig_sync #(
    parameter int NHW    = 4,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NHW-1:0] hw_in,
    output logic [NHW-1:0] hw_rise
);

    logic [NHW-1:0] stage_q [STAGES];
    logic [NHW-1:0] last_q;

    // First synchronizer flop samples the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= hw_in;
    end

    // Remaining synchronizer flops form a shift chain
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= stage_q[STAGES-1];
    end

    // Rising edge pulse on the synchronized level
    always_comb hw_rise = stage_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dac_trig_mux.sv
// Module: dac_trig_mux
// Picks one synchronized trigger pulse for a channel by its select field.
// Assumes select codes at or above NHW pick no input.
module dac_trig_mux #(
    parameter int NHW  = 4,
    parameter int SELW = 2
) (
    input  logic [NHW-1:0]  pulses,
    input  logic [SELW-1:0] sel,
    output logic            fire
);

    // Out-of-range codes yield no trigger
    always_comb begin
        fire = 1'b0;
        for (int k = 0; k < NHW; k++) begin
            if (int'(sel) == k) fire = pulses[k];
        end
    end

endmodule

// File: rtl/dac_chan.sv
// Module: dac_chan
// One DAC channel: holding register, output register, self-clearing
// software trigger bit and DMA request flop.
// Assumes hw_fire is already a synchronized single-cycle pulse.
module dac_chan
    import dac_hold_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_val,
    input  logic          trig_en,
    input  logic          dma_en,
    input  logic          sw_set,
    input  logic          hw_fire,
    input  logic          dma_ack,
    output logic [DW-1:0] out_q,
    output logic          sw_bit,
    output logic          req_q
);

    logic [DW-1:0] hold_q;
    xfer_src_e     src;
    logic          hw_req_set;

    // Decide what reloads the output register this cycle
    always_comb begin
        if (!trig_en)     src = XFER_FOLLOW;
        else if (sw_bit)  src = XFER_SW;
        else if (hw_fire) src = XFER_HW;
        else              src = XFER_NONE;
    end

    // Only a hardware trigger with DMA enabled asks for the next sample
    always_comb hw_req_set = trig_en & hw_fire & dma_en;

    // Holding register keeps the latest write
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_val;
    end

    // Output register reloads from the holding register on any transfer cause
    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= '0;
        else if (src != XFER_NONE) out_q <= hold_q;
    end

    // Software trigger bit lives one cycle, then clears itself
    always_ff @(posedge clk) begin
        if (!rst_n) sw_bit <= 1'b0;
        else        sw_bit <= sw_set;
    end

    // DMA request: set by hardware trigger, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)          req_q <= 1'b0;
        else if (hw_req_set) req_q <= 1'b1;
        else if (dma_ack)    req_q <= 1'b0;
    end

endmodule

// File: rtl/dac_hold_ctrl.sv
// Module: dac_hold_ctrl (top)
// Triggered DAC holding controller for NCH channels sharing NHW hardware
// trigger inputs. Each channel selects one input with its own field.
// Assumes configuration inputs are static while triggers are in flight.
module dac_hold_ctrl
    import dac_hold_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 12,
    parameter int NHW    = 4,
    parameter int STAGES = 2,
    parameter int SELW   = sel_width(NHW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     wr_en,
    input  logic [NCH*DW-1:0]  wr_data,
    input  logic [NCH-1:0]     trig_en,
    input  logic [NCH*SELW-1:0] trig_sel,
    input  logic [NHW-1:0]     hw_trig,
    input  logic [NCH-1:0]     sw_trig_set,
    input  logic [NCH-1:0]     dma_en,
    input  logic [NCH-1:0]     dma_ack,
    output logic [NCH*DW-1:0]  dac_out,
    output logic [NCH-1:0]     sw_trig_q,
    output logic [NCH-1:0]     dma_req
);

    logic [NHW-1:0] hw_rise;
    logic [NCH-1:0] chan_fire;

    // Shared synchronizer and edge detector for all trigger inputs
    dac_trig_sync #(.NHW(NHW), .STAGES(STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_in   (hw_trig),
        .hw_rise (hw_rise)
    );

    // One selector and one channel datapath per DAC channel
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_trig_mux #(.NHW(NHW), .SELW(SELW)) mux_i (
            .pulses (hw_rise),
            .sel    (trig_sel[c*SELW +: SELW]),
            .fire   (chan_fire[c])
        );

        dac_chan #(.DW(DW)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[c]),
            .wr_val  (wr_data[c*DW +: DW]),
            .trig_en (trig_en[c]),
            .dma_en  (dma_en[c]),
            .sw_set  (sw_trig_set[c]),
            .hw_fire (chan_fire[c]),
            .dma_ack (dma_ack[c]),
            .out_q   (dac_out[c*DW +: DW]),
            .sw_bit  (sw_trig_q[c]),
            .req_q   (dma_req[c])
        );
    end

endmodule

// File: rtl/dac_hold_ctrl_chk.sv
// Module: dac_hold_ctrl_chk
// Assertion checker bound to dac_hold_ctrl; observes ports and the
// per-channel selected trigger pulse.
module dac_hold_ctrl_chk #(
    parameter int NCH = 2,
    parameter int DW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    trig_en,
    input logic [NCH-1:0]    dma_en,
    input logic [NCH-1:0]    sw_trig_set,
    input logic [NCH-1:0]    sw_trig_q,
    input logic [NCH-1:0]    dma_ack,
    input logic [NCH-1:0]    dma_req,
    input logic [NCH*DW-1:0] dac_out,
    input logic [NCH-1:0]    chan_fire
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2
        out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_en[c] && !sw_trig_q[c] && !chan_fire[c])
            |=> $stable(dac_out[c*DW +: DW]));

        // R4
        swbit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_trig_q[c] && !sw_trig_set[c]) |=> !sw_trig_q[c]);

        // R7
        dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dma_req[c]) |-> ($past(chan_fire[c]) && $past(dma_en[c])
                                   && $past(trig_en[c])));

        // R6
        dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[c] && !dma_ack[c]) |=> dma_req[c]);
    end

endmodule

bind dac_hold_ctrl dac_hold_ctrl_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_en     (trig_en),
    .dma_en      (dma_en),
    .sw_trig_set (sw_trig_set),
    .sw_trig_q   (sw_trig_q),
    .dma_ack     (dma_ack),
    .dma_req     (dma_req),
    .dac_out     (dac_out),
    .chan_fire   (chan_fire)
);

// File: tb/dac_hold_ctrl_tb.sv
module dac_hold_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int DW   = 12;
    localparam int NHW  = 4;
    localparam int SELW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       wr_en = '0;
    logic [NCH*DW-1:0]    wr_data = '0;
    logic [NCH-1:0]       trig_en = '0;
    logic [NCH*SELW-1:0]  trig_sel = '0;
    logic [NHW-1:0]       hw_trig = '0;
    logic [NCH-1:0]       sw_trig_set = '0;
    logic [NCH-1:0]       dma_en = '0;
    logic [NCH-1:0]       dma_ack = '0;
    logic [NCH*DW-1:0]    dac_out;
    logic [NCH-1:0]       sw_trig_q;
    logic [NCH-1:0]       dma_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [DW-1:0] exp_out [NCH];

    dac_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trig_en(trig_en), .trig_sel(trig_sel), .hw_trig(hw_trig),
        .sw_trig_set(sw_trig_set), .dma_en(dma_en), .dma_ack(dma_ack),
        .dac_out(dac_out), .sw_trig_q(sw_trig_q), .dma_req(dma_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane(input int c);
        return dac_out[c*DW +: DW];
    endfunction

    // Write one channel's holding register, with optional DMA acknowledge
    task automatic write_ch(input int c, input logic [DW-1:0] v, input bit ack);
        wr_en[c] = 1'b1;
        wr_data[c*DW +: DW] = v;
        dma_ack[c] = ack;
        step();
        wr_en = '0;
        dma_ack = '0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // R1: reset state
        chk("R1 dac_out", 32'(dac_out), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 sw_trig_q", 32'(sw_trig_q), 0);
        rst_n = 1'b1;
        trig_en = 2'b11;
        step();
        chk("R1 after release", 32'(dac_out), 0);

        // R2/R3: writes do not move the output; last write wins
        write_ch(0, 12'h0AA, 0);
        write_ch(0, 12'h123, 0);
        step();
        chk("R2 ch0 unchanged", 32'(lane(0)), 0);
        // R4: software trigger timing and self-clear
        sw_trig_set = 2'b01;
        step();
        sw_trig_set = '0;
        chk("R4 bit set", 32'(sw_trig_q[0]), 1);
        chk("R4 no early update", 32'(lane(0)), 0);
        step();
        chk("R3 last write output", 32'(lane(0)), 32'h123);
        chk("R4 bit cleared", 32'(sw_trig_q[0]), 0);

        // R7: software trigger with DMA enabled raises no request
        dma_en = 2'b11;
        write_ch(1, 12'hABC, 0);
        sw_trig_set = 2'b10;
        step();
        sw_trig_set = '0;
        step();
        chk("R4 ch1 output", 32'(lane(1)), 32'hABC);
        step();
        chk("R7 no dma on sw", 32'(dma_req), 0);
        exp_out[0] = 12'h123;
        exp_out[1] = 12'hABC;

        // R5/R6: sweep every select value against every input on both channels
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NHW; s++) begin
                for (int j = 0; j < NHW; j++) begin
                    logic [DW-1:0] v;
                    v = DW'(c*12'h400 + s*12'h40 + j*4 + 1);
                    trig_sel[c*SELW +: SELW] = SELW'(s);
                    dma_en = NCH'(1 << c);
                    write_ch(c, v, 1);
                    chk("R6 ack clears", 32'(dma_req[c]), 0);
                    chk("R2 sweep hold", 32'(lane(c)), 32'(exp_out[c]));
                    hw_trig[j] = 1'b1;
                    step(); step();
                    chk("R5 not yet", 32'(lane(c)), 32'(exp_out[c]));
                    step();
                    if (j == s) exp_out[c] = v;
                    chk("R5 select/latency", 32'(lane(c)), 32'(exp_out[c]));
                    chk("R6 request", 32'(dma_req[c]), 32'(j == s));
                    step(); step();
                    chk("R6 request held", 32'(dma_req[c]), 32'(j == s));
                    chk("R5 level no retrigger", 32'(lane(c)), 32'(exp_out[c]));
                    hw_trig[j] = 1'b0;
                    step(); step(); step();
                end
            end
        end

        // R9: both channels on one trigger update together
        trig_sel = {2'd2, 2'd2};
        dma_en = 2'b11;
        wr_en = 2'b11;
        wr_data = {12'h5A5, 12'h3C3};
        dma_ack = 2'b11;
        step();
        wr_en = '0;
        dma_ack = '0;
        hw_trig[2] = 1'b1;
        step(); step();
        chk("R9 ch0 before", 32'(lane(0)), 32'(exp_out[0]));
        chk("R9 ch1 before", 32'(lane(1)), 32'(exp_out[1]));
        step();
        chk("R9 ch0 same edge", 32'(lane(0)), 32'h3C3);
        chk("R9 ch1 same edge", 32'(lane(1)), 32'h5A5);
        chk("R9 both requests", 32'(dma_req), 32'h3);
        hw_trig[2] = 1'b0;
        step(); step(); step();

        // R10: trigger coincident with a write outputs the older value
        write_ch(0, 12'h111, 1);
        sw_trig_set = 2'b01;
        step();
        sw_trig_set = '0;
        wr_en[0] = 1'b1;
        wr_data[0 +: DW] = 12'h222;
        step();
        wr_en = '0;
        chk("R10 old value out", 32'(lane(0)), 32'h111);
        chk("R4 cleared after transfer", 32'(sw_trig_q[0]), 0);
        sw_trig_set = 2'b01;
        step();
        sw_trig_set = '0;
        step();
        chk("R10 new value later", 32'(lane(0)), 32'h222);
        chk("R7 no dma after sw", 32'(dma_req[0]), 0);

        // R11: hardware trigger with DMA disabled
        dma_en = 2'b00;
        trig_sel[SELW +: SELW] = 2'd1;
        write_ch(1, 12'h777, 1);
        hw_trig[1] = 1'b1;
        step(); step(); step();
        chk("R11 output", 32'(lane(1)), 32'h777);
        chk("R11 no request", 32'(dma_req[1]), 0);
        hw_trig[1] = 1'b0;
        step(); step(); step();

        // R8: triggering disabled, output follows holding
        trig_en = 2'b00;
        dma_en = 2'b11;
        trig_sel[0 +: SELW] = 2'd0;
        write_ch(0, 12'h456, 0);
        chk("R8 not same edge", 32'(lane(0)), 32'h222);
        step();
        chk("R8 follows", 32'(lane(0)), 32'h456);
        hw_trig[0] = 1'b1;
        step(); step(); step();
        chk("R8 hw no request", 32'(dma_req[0]), 0);
        chk("R8 output kept", 32'(lane(0)), 32'h456);
        hw_trig[0] = 1'b0;
        sw_trig_set = 2'b01;
        step();
        sw_trig_set = '0;
        chk("R4 bit set when disabled", 32'(sw_trig_q[0]), 1);
        step();
        chk("R8 sw no request", 32'(dma_req[0]), 0);
        chk("R4 bit clears when disabled", 32'(sw_trig_q[0]), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule